// File: doc/BRIEF.md
# Rolling Shutter Row Sequencer

This block drives the vertical addressing of an image array that uses an electronic rolling shutter. Once a frame starts, two row pointers step through the programmed rows one line at a time. The read pointer marks the row being sampled. The reset pointer marks the row whose exposure is being restarted. The reset pointer runs ahead of the read pointer by the programmed integration distance, counted in lines. Both pointers wrap inside the programmed window, so every row is exposed for the same number of line times.

Each line is a blanking interval, during which the row is sampled, followed by the active pixel interval, during which `line_valid_o` is high. One frame therefore lasts lines × (blank + pixels) clock cycles. The frame-start input is filtered and acts only after it has been held high for several consecutive cycles. A suspend input freezes the whole sequence for as long as it is held. All configuration values are parallel inputs and are captured only when a frame is accepted.

Top module: `rss_row_seq`

## Requirements
- R1: During and directly after reset, both row outputs read 0 and all sync and valid outputs are low.
- R2: A frame is accepted on the clock edge where `frame_start_i` has been sampled high for 3 consecutive edges. A pulse of 1 or 2 cycles starts nothing. Holding the input high past 3 cycles starts only one frame.
- R3: A frame-start qualified while a frame is running is ignored.
- R4: Each line is `blank` cycles with `line_valid_o` low, followed by `pixels` cycles with `line_valid_o` high. `line_sync_o` is high only in the first blank cycle of each line.
- R5: During line k (counting from 0), `read_row_o` equals start row + k, truncated to 12 bits.
- R6: During line k, `reset_row_o` equals start row + ((k + integration) mod lines), truncated to 12 bits.
- R7: Captured values are clamped as follows. Lines 0 becomes 1, and lines above 3014 become 3014. Integration 0 becomes 1, and integration above lines becomes lines. A blank or pixel count of 0 becomes 1.
- R8: While `suspend_i` is high during a frame, all outputs hold their values. Each suspended cycle lengthens the frame by exactly one cycle.
- R9: Configuration inputs are captured only at frame acceptance. Changes made during a frame do not affect that frame.
- R10: `frame_valid_o` is high from the first cycle of line 0 through the last active cycle of the last line, for lines × (blank + pixels) cycles in total. `frame_sync_o` pulses together with `line_sync_o` on line 0 only. Outside a frame, both row outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start_i | input | 1 | Frame start request; must be held for 3 cycles |
| suspend_i | input | 1 | Freezes the sequence while high |
| cfg_lines_i | input | 12 | Number of lines per frame |
| cfg_int_i | input | 12 | Integration distance in lines |
| cfg_start_i | input | 12 | First row of the window |
| cfg_blank_i | input | 8 | Row blanking length in cycles |
| cfg_pixels_i | input | 11 | Active pixel cycles per line |
| read_row_o | output | 12 | Row currently being read |
| reset_row_o | output | 12 | Row currently being reset |
| line_sync_o | output | 1 | First cycle of each line |
| frame_sync_o | output | 1 | First cycle of each frame |
| line_valid_o | output | 1 | Active pixel interval |
| frame_valid_o | output | 1 | Frame in progress |

## Verification
The suspend property assumes `suspend_i` changes only between clock edges. It also assumes a frame cannot begin on the same edge at which the suspended frame is checked. The block guarantees the second point, because it refuses frame starts while busy. The frame-start property assumes the first three sampled edges after reset belong to the post-reset window. The stimulus therefore keeps `frame_start_i` low while reset is applied. All inputs change on the falling clock edge, so configuration, start and suspend are stable at every rising edge. Configuration values stay small, so that start row plus lines stays within the 12-bit row range except where truncation is exercised on purpose.

// File: rtl/rss_pkg.sv
// Shared types for the rolling shutter row sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package rss_pkg;
    typedef enum logic {
        PH_BLANK  = 1'b0,
        PH_ACTIVE = 1'b1
    } phase_e;
endpackage

// File: rtl/rss_start_filter.sv
// Qualifies the frame-start request: emits one pulse on the edge where the
// input has been sampled high for HOLD consecutive edges.
// Assumes: HOLD >= 1; input is synchronous to clk.
module rss_start_filter #(
    parameter int HOLD = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic ok_o
);
    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD - 1);
    localparam logic [CW-1:0] SAT  = CW'(HOLD);

    logic [CW-1:0] run_q;

    // Count consecutive high samples, saturating at HOLD.
    always_ff @(posedge clk) begin
        if (!rst_n)          run_q <= '0;
        else if (!req_i)     run_q <= '0;
        else if (run_q != SAT) run_q <= run_q + 1'b1;
    end

    assign ok_o = req_i && (run_q == LAST);
endmodule

// File: rtl/rss_line_timer.sv
// Splits each line into a blanking phase and an active pixel phase.
// Assumes: blank_i and pix_i are >= 1 and stable while en_i can be high.
module rss_line_timer
    import rss_pkg::*;
#(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          en_i,
    input  logic [CW-1:0] blank_i,
    input  logic [CW-1:0] pix_i,
    output phase_e        phase_o,
    output logic          first_o,
    output logic          line_end_o
);
    logic [CW-1:0] cnt_q;
    phase_e        ph_q;

    // Advance the in-line cycle counter and switch phases at the limits.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) begin
            ph_q  <= PH_BLANK;
            cnt_q <= '0;
        end else if (en_i) begin
            if (ph_q == PH_BLANK) begin
                if (cnt_q == blank_i - 1'b1) begin
                    ph_q  <= PH_ACTIVE;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                if (cnt_q == pix_i - 1'b1) begin
                    ph_q  <= PH_BLANK;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign phase_o    = ph_q;
    assign first_o    = (ph_q == PH_BLANK) && (cnt_q == '0);
    assign line_end_o = en_i && (ph_q == PH_ACTIVE) && (cnt_q == pix_i - 1'b1);
endmodule

// File: rtl/rss_row_pointer.sv
// Row offset counter that wraps from limit-1 back to zero; loadable.
// Assumes: limit_i >= 1 and load_val_i < limit_i when stepping.
module rss_row_pointer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         step_i,
    input  logic [W-1:0] limit_i,
    output logic [W-1:0] ofs_o
);
    logic [W-1:0] ofs_q;

    // Load at frame start, otherwise step with wrap inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n)       ofs_q <= '0;
        else if (load_i)  ofs_q <= load_val_i;
        else if (step_i)  ofs_q <= (ofs_q == limit_i - 1'b1) ? '0 : ofs_q + 1'b1;
    end

    assign ofs_o = ofs_q;
endmodule

// File: rtl/rss_row_seq.sv
// Rolling shutter row sequencer top: captures configuration at frame start,
// runs the line timer and the read and reset row pointers, and drives the
// sync and valid outputs.
// Assumes: inputs synchronous to clk; start row + lines fits the row width
// or wrap by truncation is acceptable.
module rss_row_seq
    import rss_pkg::*;
#(
    parameter int ROW_W      = 12,
    parameter int BLANK_W    = 8,
    parameter int PIX_W      = 11,
    parameter int MAX_LINES  = 3014,
    parameter int START_HOLD = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start_i,
    input  logic               suspend_i,
    input  logic [ROW_W-1:0]   cfg_lines_i,
    input  logic [ROW_W-1:0]   cfg_int_i,
    input  logic [ROW_W-1:0]   cfg_start_i,
    input  logic [BLANK_W-1:0] cfg_blank_i,
    input  logic [PIX_W-1:0]   cfg_pixels_i,
    output logic [ROW_W-1:0]   read_row_o,
    output logic [ROW_W-1:0]   reset_row_o,
    output logic               line_sync_o,
    output logic               frame_sync_o,
    output logic               line_valid_o,
    output logic               frame_valid_o
);
    localparam int CW = (BLANK_W > PIX_W) ? BLANK_W : PIX_W;
    localparam logic [ROW_W-1:0] LMAX = ROW_W'(MAX_LINES);

    logic             start_ok, accept, busy_q, adv, line_end, last_line, first;
    phase_e           phase;
    logic [ROW_W-1:0] lines_c, int_c, rst_load;
    logic [ROW_W-1:0] lines_q, int_q, start_q, rd_ofs, rs_ofs;
    logic [CW-1:0]    blank_q, pix_q;

    rss_start_filter #(.HOLD(START_HOLD)) u_filt (
        .clk(clk), .rst_n(rst_n), .req_i(frame_start_i), .ok_o(start_ok)
    );

    assign accept = start_ok && !busy_q;
    assign adv    = busy_q && !suspend_i;

    // Clamp the programmed line count and integration distance.
    always_comb begin
        if (cfg_lines_i == '0)      lines_c = ROW_W'(1);
        else if (cfg_lines_i > LMAX) lines_c = LMAX;
        else                         lines_c = cfg_lines_i;
        if (cfg_int_i == '0)         int_c = ROW_W'(1);
        else if (cfg_int_i > lines_c) int_c = lines_c;
        else                         int_c = cfg_int_i;
        rst_load = (int_c == lines_c) ? '0 : int_c;
    end

    // Capture configuration only when a frame is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lines_q <= ROW_W'(1);
            int_q   <= ROW_W'(1);
            start_q <= '0;
            blank_q <= CW'(1);
            pix_q   <= CW'(1);
        end else if (accept) begin
            lines_q <= lines_c;
            int_q   <= int_c;
            start_q <= cfg_start_i;
            blank_q <= (cfg_blank_i == '0)  ? CW'(1) : CW'(cfg_blank_i);
            pix_q   <= (cfg_pixels_i == '0) ? CW'(1) : CW'(cfg_pixels_i);
        end
    end

    rss_line_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load_i(accept), .en_i(adv),
        .blank_i(blank_q), .pix_i(pix_q),
        .phase_o(phase), .first_o(first), .line_end_o(line_end)
    );

    rss_row_pointer #(.W(ROW_W)) u_read (
        .clk(clk), .rst_n(rst_n), .load_i(accept), .load_val_i('0),
        .step_i(line_end), .limit_i(lines_q), .ofs_o(rd_ofs)
    );

    rss_row_pointer #(.W(ROW_W)) u_reset (
        .clk(clk), .rst_n(rst_n), .load_i(accept), .load_val_i(rst_load),
        .step_i(line_end), .limit_i(lines_q), .ofs_o(rs_ofs)
    );

    assign last_line = line_end && (rd_ofs == lines_q - 1'b1);

    // Frame-in-progress flag: set on acceptance, cleared after the last line.
    always_ff @(posedge clk) begin
        if (!rst_n)         busy_q <= 1'b0;
        else if (accept)    busy_q <= 1'b1;
        else if (last_line) busy_q <= 1'b0;
    end

    assign read_row_o    = busy_q ? start_q + rd_ofs : '0;
    assign reset_row_o   = busy_q ? start_q + rs_ofs : '0;
    assign line_sync_o   = busy_q && first;
    assign frame_sync_o  = busy_q && first && (rd_ofs == '0);
    assign line_valid_o  = busy_q && (phase == PH_ACTIVE);
    assign frame_valid_o = busy_q;
endmodule

// File: rtl/rss_row_seq_chk.sv
// Property checker for rss_row_seq, attached by bind.
// Assumes: inputs change away from the rising clock edge.
module rss_row_seq_chk #(
    parameter int ROW_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start_i,
    input logic             suspend_i,
    input logic [ROW_W-1:0] read_row_o,
    input logic [ROW_W-1:0] reset_row_o,
    input logic             line_sync_o,
    input logic             frame_sync_o,
    input logic             line_valid_o,
    input logic             frame_valid_o
);
    AST_SYNC_NOT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_sync_o && line_valid_o)); // R4
    AST_SYNC_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        line_sync_o |-> frame_valid_o); // R4
    AST_VALID_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid_o |-> frame_valid_o); // R10
    AST_FSYNC_WITH_LSYNC: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync_o |-> line_sync_o); // R10
    AST_IDLE_ROWS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid_o |-> (read_row_o == '0 && reset_row_o == '0)); // R10
    AST_SUSPEND_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (suspend_i && frame_valid_o) |=> ($stable(read_row_o) && $stable(reset_row_o)
                                          && $stable(line_valid_o) && frame_valid_o)); // R8
    AST_START_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_valid_o) |-> ($past(frame_start_i, 1) && $past(frame_start_i, 2)
                                  && $past(frame_start_i, 3))); // R2
endmodule

bind rss_row_seq rss_row_seq_chk #(.ROW_W(ROW_W)) chk_i (.*);

// File: tb/rss_row_seq_tb_top.sv
// Bench for rss_row_seq: a behavioural frame-position model, compared on every cycle.
module rss_row_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start_i = 1'b0;
    logic        suspend_i = 1'b0;
    logic [11:0] cfg_lines_i = 12'd5, cfg_int_i = 12'd2, cfg_start_i = 12'd10;
    logic [7:0]  cfg_blank_i = 8'd3;
    logic [10:0] cfg_pixels_i = 11'd4;
    logic [11:0] read_row_o, reset_row_o;
    logic        line_sync_o, frame_sync_o, line_valid_o, frame_valid_o;

    int checks = 0, failures = 0;
    int fv_cnt = 0, fs_cnt = 0;
    bit finished = 0;

    // Behavioural model state
    int  m_hold = 0, m_pos = 0, mL = 1, mI = 1, mS = 0, mB = 1, mP = 1;
    bit  m_busy = 0;

    always #5 clk = ~clk;

    rss_row_seq dut_i (.*);

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Model update at each rising edge from the sampled inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            m_hold = 0; m_busy = 0; m_pos = 0;
        end else begin
            bit acc;
            acc = frame_start_i && (m_hold == 2) && !m_busy;
            m_hold = frame_start_i ? ((m_hold < 3) ? m_hold + 1 : 3) : 0;
            if (acc) begin
                mL = (cfg_lines_i == 0) ? 1 : ((cfg_lines_i > 3014) ? 3014 : int'(cfg_lines_i));
                mI = (cfg_int_i == 0) ? 1 : ((cfg_int_i > mL) ? mL : int'(cfg_int_i));
                mS = cfg_start_i;
                mB = (cfg_blank_i == 0) ? 1 : int'(cfg_blank_i);
                mP = (cfg_pixels_i == 0) ? 1 : int'(cfg_pixels_i);
                m_busy = 1; m_pos = 0;
            end else if (m_busy && !suspend_i) begin
                m_pos++;
                if (m_pos == mL * (mB + mP)) m_busy = 0;
            end
        end
    end

    // Compare on every falling edge; all outputs depend only on state
    always @(negedge clk) begin
        int per, ln, w, er, es, el, ev, ef;
        if (m_busy) begin
            per = mB + mP; ln = m_pos / per; w = m_pos % per;
            er = (mS + ln) & 4095;
            es = (mS + ((ln + mI) % mL)) & 4095;
            el = (w == 0); ev = (w >= mB); ef = (m_pos == 0);
        end else begin
            er = 0; es = 0; el = 0; ev = 0; ef = 0;
        end
        check("R5 read_row", read_row_o, er);
        check("R6 reset_row", reset_row_o, es);
        check("R4 line_sync", line_sync_o, el);
        check("R4 line_valid", line_valid_o, ev);
        check("R10 frame_valid", frame_valid_o, m_busy);
        check("R10 frame_sync", frame_sync_o, ef);
        if (frame_valid_o) fv_cnt++;
        if (frame_sync_o) fs_cnt++;
    end

    task automatic set_cfg(int l, int i, int s, int b, int p);
        cfg_lines_i = 12'(l); cfg_int_i = 12'(i); cfg_start_i = 12'(s);
        cfg_blank_i = 8'(b); cfg_pixels_i = 11'(p);
    endtask

    task automatic pulse_start(int n);
        @(negedge clk); frame_start_i = 1'b1;
        repeat (n) @(negedge clk);
        frame_start_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (frame_valid_o) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset read_row", read_row_o, 0);
        check("R1 reset frame_valid", frame_valid_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 post-reset reset_row", reset_row_o, 0);
        check("R1 post-reset line_valid", line_valid_o, 0);

        // R2: short pulses start nothing
        fv_cnt = 0;
        pulse_start(1); repeat (2) @(negedge clk);
        pulse_start(2); repeat (8) @(negedge clk);
        check("R2 short pulses ignored", fv_cnt, 0);

        // R10 basic frame length and R5/R6 via per-cycle model
        fv_cnt = 0; fs_cnt = 0;
        set_cfg(5, 2, 10, 3, 4);
        pulse_start(3); wait_idle();
        check("R10 frame length", fv_cnt, 35);
        check("R10 one frame_sync", fs_cnt, 1);

        // R3/R9: cfg change and restart request mid-frame
        fv_cnt = 0; fs_cnt = 0;
        pulse_start(3);
        repeat (5) @(negedge clk);
        set_cfg(9, 7, 200, 9, 9);
        pulse_start(5);
        wait_idle();
        check("R9 config held during frame", fv_cnt, 35);
        check("R3 restart ignored", fs_cnt, 1);

        // R2: long hold yields a single frame
        set_cfg(3, 1, 40, 2, 2);
        fv_cnt = 0; fs_cnt = 0;
        pulse_start(20); wait_idle();
        check("R2 long hold single frame", fs_cnt, 1);
        check("R2 long hold frame length", fv_cnt, 12);

        // R8: suspend mid-frame for 6 cycles
        set_cfg(6, 4, 100, 2, 3);
        fv_cnt = 0;
        pulse_start(3);
        repeat (7) @(negedge clk);
        suspend_i = 1'b1;
        repeat (6) @(negedge clk);
        suspend_i = 1'b0;
        wait_idle();
        check("R8 suspend stretches frame", fv_cnt, 30 + 6);

        // R7: zero configuration clamps to 1
        set_cfg(0, 0, 55, 0, 0);
        fv_cnt = 0;
        frame_start_i = 1'b1;
        repeat (3) @(negedge clk);
        frame_start_i = 1'b0;
        check("R7 clamped reset_row", reset_row_o, 55);
        wait_idle();
        check("R7 zero cfg frame length", fv_cnt, 2);

        // R7: integration above lines clamps to lines
        set_cfg(4, 9, 300, 1, 2);
        @(negedge clk); frame_start_i = 1'b1;
        repeat (3) @(negedge clk);
        frame_start_i = 1'b0;
        check("R7 int clamp reset_row", reset_row_o, 300);
        wait_idle();

        // R6 wrap near the top of the row range (truncation)
        set_cfg(6, 3, 4093, 1, 1);
        pulse_start(3); wait_idle();

        // R7: line count above maximum clamps to 3014
        set_cfg(4000, 10, 0, 1, 1);
        fv_cnt = 0;
        pulse_start(3); wait_idle();
        check("R7 lines clamp frame length", fv_cnt, 6028);

        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule